// File: doc/BRIEF.md
# Serial Control Register Port

This block is the write-only control port of a multichannel converter. A host shifts a 16-bit word in on a data pin, most significant bit first, with one bit taken on each rising edge of a serial clock. A separate strobe pin then commits the word. The top four bits of the word choose a target register, the next two bits are a reserved gap, and the low ten bits are the value to store. Nine registers can be reached: three general control registers and six per-channel volume registers. The contents of all nine are driven out in parallel to the converter datapath.

The serial clock and the strobe need not be related to the system clock. All three serial pins pass through a synchronizer, and the edges are found in the system clock domain. A word is written only when exactly sixteen serial clock edges arrived before the strobe rose. A short or long frame is thrown away, and so is a word that names one of the seven unused addresses. Control registers reset to zero and volume registers reset to full scale.

Top module: `ctrl_word_port`

## Requirements
- R1: After reset all three control outputs read 0 and every volume output reads 10'h3FF (full scale).
- R2: The word is taken from the data pin on rising edges of the serial clock, with the first bit taken as bit 15 and the last as bit 0. The value on the pin at falling edges is not used.
- R3: A rising edge of the strobe commits the word only if exactly 16 serial clock rising edges came after the previous strobe rise. With 15 or 17 edges, or with none, no register changes. The edge count restarts at every strobe rise.
- R4: Address field bits 15:12 select the control registers: value 0 writes control 1, value 1 writes control 2, and value 8 writes control 3.
- R5: Address values 2 through 7 write volume 1 through volume 6, in that order. Volume n appears at bits [10n-1:10n-10] of the volume bus.
- R6: A committed word with address 9 through 15 leaves all nine registers unchanged.
- R7: Bits 9:0 of the word are the stored value. Bits 11:10 have no effect on which register is written or on the value stored.
- R8: A register keeps its value until a committed word addresses it. Each strobe rise performs at most one write.
- R9: Serial clock, data and strobe are synchronized into the system clock domain. Each level of the serial clock and the strobe must last at least three system clock cycles to be seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_latch_i | input | 1 | Commit strobe; its rising edge writes the word |
| cfg1_o | output | 10 | Control register 1 |
| cfg2_o | output | 10 | Control register 2 |
| cfg3_o | output | 10 | Control register 3 |
| vol_o | output | 60 | Six volume registers, volume 1 in the low bits |

## Verification
The hardest situations to reach are a committed word that writes nothing: a frame one bit short or one bit long, a strobe with no clocks before it, or an otherwise valid frame to an unused address. In each case the outputs must be identical to what they were before. The stimulus mixes random addresses over the full 4-bit range with random reserved bits and random frame lengths of 15, 16 or 17 bits. It adds directed frames for each of these drop cases, so the bench compares all nine outputs after every frame that should have been discarded. The bench changes the data pin at each falling serial edge, so a design that samples on the wrong edge reads shifted words.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
    parameter int DATA_W  = 10;
    parameter int ADDR_W  = 4;
    parameter int RSV_W   = 2;
    parameter int NUM_CFG = 3;
    parameter int NUM_VOL = 6;

    localparam int WORD_W  = ADDR_W + RSV_W + DATA_W;
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int NUM_REG = NUM_CFG + NUM_VOL;

    // address map: two control slots, then the volume block, then the last control slot
    localparam logic [ADDR_W-1:0] ADDR_CFG1 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CFG2 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_VOL0 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_CFG3 = ADDR_W'(2 + NUM_VOL);

    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [RSV_W-1:0]  rsv;
        data_t             data;
    } word_t;

    // one-hot select: bits [NUM_CFG-1:0] control, bits above volume
    function automatic logic [NUM_REG-1:0] decode_sel(input logic [ADDR_W-1:0] a);
        logic [NUM_REG-1:0] s;
        s = '0;
        if (a == ADDR_CFG1) s[0] = 1'b1;
        if (a == ADDR_CFG2) s[1] = 1'b1;
        if (a == ADDR_CFG3) s[2] = 1'b1;
        for (int i = 0; i < NUM_VOL; i++) begin
            if (a == ADDR_VOL0 + ADDR_W'(i)) s[NUM_CFG + i] = 1'b1;
        end
        return s;
    endfunction
endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.pipe[STAGES-1];
    assign rise_o  = st_q.pipe[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/ctlp_shifter.sv
module ctlp_shifter
    import ctlp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_rise_i,
    input  logic  bit_val_i,
    input  logic  commit_rise_i,
    output logic  wr_valid_o,
    output word_t wr_word_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        word_t             word;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (bit_rise_i) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], bit_val_i};
            if (st_q.cnt != SAT_CNT) st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (commit_rise_i) begin
            st_d.cnt = '0;
            if (st_q.cnt == FULL_CNT) begin
                st_d.vld  = 1'b1;
                st_d.word = word_t'(st_q.sh);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid_o = st_q.vld;
    assign wr_word_o  = st_q.word;
endmodule

// File: rtl/ctlp_regfile.sv
module ctlp_regfile
    import ctlp_pkg::*;
#(
    parameter logic [DATA_W-1:0] VOL_RST = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid_i,
    input  word_t                      wr_word_i,
    output logic [NUM_CFG*DATA_W-1:0]  cfg_o,
    output logic [NUM_VOL*DATA_W-1:0]  vol_o
);
    typedef struct packed {
        data_t [NUM_CFG-1:0] cfg;
        data_t [NUM_VOL-1:0] vol;
    } reg_st_t;

    reg_st_t            st_d, st_q;
    logic [NUM_REG-1:0] sel;

    assign sel = wr_valid_i ? decode_sel(wr_word_i.addr) : '0;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CFG; c++) begin
            if (sel[c]) st_d.cfg[c] = wr_word_i.data;
        end
        for (int v = 0; v < NUM_VOL; v++) begin
            if (sel[NUM_CFG + v]) st_d.vol[v] = wr_word_i.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= '0;
            for (int v = 0; v < NUM_VOL; v++) st_q.vol[v] <= VOL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
            assign cfg_o[g*DATA_W +: DATA_W] = st_q.cfg[g];
        end
        for (genvar g = 0; g < NUM_VOL; g++) begin : g_vol
            assign vol_o[g*DATA_W +: DATA_W] = st_q.vol[g];
        end
    endgenerate
endmodule

// File: rtl/ctrl_word_port.sv
module ctrl_word_port
    import ctlp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_clk_i,
    input  logic                      ser_dat_i,
    input  logic                      ser_latch_i,
    output logic [DATA_W-1:0]         cfg1_o,
    output logic [DATA_W-1:0]         cfg2_o,
    output logic [DATA_W-1:0]         cfg3_o,
    output logic [NUM_VOL*DATA_W-1:0] vol_o
);
    localparam int PIN_CLK = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_LAT = 2;

    logic [2:0]                pin_lvl;
    logic [2:0]                pin_rise;
    logic                      wr_valid;
    word_t                     wr_word;
    logic [NUM_CFG*DATA_W-1:0] cfg_flat;

    ctlp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_latch_i, ser_dat_i, ser_clk_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    ctlp_shifter u_shf (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_rise_i    (pin_rise[PIN_CLK]),
        .bit_val_i     (pin_lvl[PIN_DAT]),
        .commit_rise_i (pin_rise[PIN_LAT]),
        .wr_valid_o    (wr_valid),
        .wr_word_o     (wr_word)
    );

    ctlp_regfile u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .wr_word_i  (wr_word),
        .cfg_o      (cfg_flat),
        .vol_o      (vol_o)
    );

    assign cfg1_o = cfg_flat[0*DATA_W +: DATA_W];
    assign cfg2_o = cfg_flat[1*DATA_W +: DATA_W];
    assign cfg3_o = cfg_flat[2*DATA_W +: DATA_W];
endmodule

// File: rtl/ctlp_checker.sv
module ctlp_checker
    import ctlp_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_valid,
    input word_t                     wr_word,
    input logic [NUM_CFG*DATA_W-1:0] cfg_flat,
    input logic [NUM_VOL*DATA_W-1:0] vol_flat
);
    // R8: nothing moves without a committed word
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(cfg_flat) && $stable(vol_flat)));

    // R3, R8: one strobe edge gives a single write pulse
    p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R6: unused addresses leave every register alone
    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_word.addr > ADDR_CFG3) |=> ($stable(cfg_flat) && $stable(vol_flat)));

    // R4: control slots
    p_cfg1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_word.addr == ADDR_CFG1) |=> cfg_flat[0 +: DATA_W] == $past(wr_word.data));
    p_cfg2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_word.addr == ADDR_CFG2) |=> cfg_flat[DATA_W +: DATA_W] == $past(wr_word.data));
    p_cfg3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_word.addr == ADDR_CFG3) |=> cfg_flat[2*DATA_W +: DATA_W] == $past(wr_word.data));

    // R5: volume slots
    generate
        for (genvar g = 0; g < NUM_VOL; g++) begin : g_vchk
            p_vol_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_word.addr == ADDR_VOL0 + ADDR_W'(g))
                |=> vol_flat[g*DATA_W +: DATA_W] == $past(wr_word.data));
        end
    endgenerate
endmodule

bind ctrl_word_port ctlp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_word  (wr_word),
    .cfg_flat (cfg_flat),
    .vol_flat (vol_o)
);

// File: tb/ctrl_word_port_tb.sv
module ctrl_word_port_tb;
    localparam int HALF = 5;   // system clocks per serial half period
    localparam int DW   = 10;
    localparam int NV   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_clk = 1'b0;
    logic          ser_dat = 1'b0;
    logic          ser_latch = 1'b0;
    logic [DW-1:0] cfg1, cfg2, cfg3;
    logic [NV*DW-1:0] vol;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] m_cfg [3];
    logic [DW-1:0] m_vol [NV];

    always #5 clk = ~clk;

    ctrl_word_port u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (ser_clk),
        .ser_dat_i   (ser_dat),
        .ser_latch_i (ser_latch),
        .cfg1_o      (cfg1),
        .cfg2_o      (cfg2),
        .cfg3_o      (cfg3),
        .vol_o       (vol)
    );

    function automatic logic [15:0] mk_word(input int a, input int r, input int d);
        return {a[3:0], r[1:0], d[9:0]};
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        @(negedge clk);
        chk({ctx, " R4 cfg1"}, cfg1, m_cfg[0]);
        chk({ctx, " R4 cfg2"}, cfg2, m_cfg[1]);
        chk({ctx, " R4 cfg3"}, cfg3, m_cfg[2]);
        for (int v = 0; v < NV; v++)
            chk($sformatf("%s R5 vol%0d", ctx, v + 1), vol[v*DW +: DW], m_vol[v]);
    endtask

    // model of R3..R7
    task automatic model(input logic [31:0] bits, input int n);
        logic [3:0]    a;
        logic [DW-1:0] d;
        if (n != 16) return;
        a = bits[15:12];
        d = bits[9:0];
        if (a == 0)      m_cfg[0] = d;
        else if (a == 1) m_cfg[1] = d;
        else if (a <= 7) m_vol[a-2] = d;
        else if (a == 8) m_cfg[2] = d;
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_dat = bits[i];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
            ser_dat = ~bits[i];   // R2: value at the falling edge must not be used
        end
        repeat (HALF) @(negedge clk);
        ser_latch = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_latch = 1'b0;
        repeat (8) @(negedge clk);
        model(bits, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int c = 0; c < 3; c++) m_cfg[c] = '0;
        for (int v = 0; v < NV; v++) m_vol[v] = 10'h3FF;
        repeat (4) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R1 after release");

        // directed: every valid slot, MSB/LSB patterns (R2, R4, R5)
        for (int a = 0; a <= 8; a++) begin
            send({16'h0, mk_word(a, 0, 10'h200 | (a * 37))}, 16);
            check_all($sformatf("R2 addr%0d", a));
        end
        send({16'h0, mk_word(0, 0, 10'h001)}, 16);
        check_all("R2 lsb only");
        // R7: reserved bits set
        send({16'h0, mk_word(3, 3, 10'h155)}, 16);
        check_all("R7 rsv bits");
        send({16'h0, mk_word(8, 2, 10'h2AA)}, 16);
        check_all("R7 rsv bits cfg3");
        // R6: unused addresses, data would be visible
        send({16'h0, mk_word(9, 0, 10'h000)}, 16);
        check_all("R6 addr9");
        send({16'h0, mk_word(15, 0, 10'h000)}, 16);
        check_all("R6 addr15");
        // R3: short, long, empty frames
        send({17'h0, mk_word(2, 0, 10'h0F0)} >> 1, 15);
        check_all("R3 short");
        send({16'h0, mk_word(2, 0, 10'h0F0)} << 1, 17);
        check_all("R3 long");
        send(32'h0, 0);
        check_all("R3 empty");
        // R3: count restarts after a dropped frame
        send({16'h0, mk_word(4, 0, 10'h3C3)}, 16);
        check_all("R3 restart");

        // R8, R9 and the rest under random traffic
        for (int k = 0; k < 60; k++) begin
            int len;
            int pick = $urandom_range(0, 9);
            len = (pick == 0) ? 15 : (pick == 1) ? 17 : 16;
            send({16'h0, mk_word($urandom_range(0, 15), $urandom_range(0, 3),
                                 $urandom_range(0, 1023))} << (len == 17), len);
            check_all($sformatf("R8 rnd%0d", k));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule